// File: doc/BRIEF.md
# Global Memory Access Coalescer

This block plans the memory transactions for one load or store issued by a group of 16 lanes. Each lane carries an active flag and the byte address of the 32-bit word it wants. The block merges the lane addresses into as few aligned transactions as it can. Each transaction is 32, 64 or 128 bytes and starts on an address that is a multiple of its own size.

After a request is accepted, the block presents one transaction at a time on a valid/ready output. Each transaction carries its base address, a size code and the mask of lanes it serves. When the last one has been taken, the block raises a one-cycle completion pulse and then becomes ready for the next request. The block moves no data. It only produces the transaction list.

Grouping does not depend on the order of the lanes: any lanes that fall in the same 128-byte segment share a transaction. Each transaction is then cut down to the smallest aligned size that still covers every byte its lanes need.

Top module: `mem_coalescer`

## Requirements
- R1: While reset is applied, and after it is released, `req_ready` is 1 while `txn_valid` and `done` are 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the block is idle. The first transaction, or the completion pulse if no lane is active, appears in the cycle right after acceptance.
- R3: Transactions are issued in order of the lowest-numbered active lane not yet served. Each `txn_lanes` mask (bit i means lane i) holds every unserved active lane whose address lies in the same 128-byte aligned segment as that lane, and no other lane.
- R4: Each lane needs the 4 bytes starting at its address with bits [1:0] cleared. `txn_size` encodes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. The chosen size is the smallest of the three whose aligned block holds all the needed bytes of the grouped lanes. `txn_base` is that block's start address.
- R5: When every active address lies in one aligned segment, exactly one transaction is issued, in whatever order the lanes visit the words.
- R6: Sixteen lanes reading at a stride of 2 words from a 128-byte-aligned base give a single 128-byte transaction. At a stride of 3 words they give one 128-byte transaction followed by one 64-byte transaction.
- R7: Lanes with their `req_active` bit at 0 never appear in a mask and have no effect on base or size. A request with no active lane produces no transaction, only the completion pulse.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, the presented transaction holds unchanged.
- R9: `done` is a one-cycle pulse in the cycle after the handshake of the last transaction. `req_ready` returns in the cycle after `done`. A request presented while the block is busy or completing is not taken.
- R10: When every active lane lies in a different 128-byte segment, 16 transactions of 32 bytes are issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_active | input | LANES | Per-lane active flags |
| req_addr | input | LANES*AW | Lane byte addresses, lane i at bits [i*AW +: AW] |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | AW | Aligned start address of the transaction |
| txn_size | output | SZW | Size code: 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_lanes | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse after the last transaction |

## Verification
The first transaction, or the completion pulse for an empty request, is due one cycle after the accepting edge. The bench checks for it at the first falling edge after that edge.

Each later transaction is due one cycle after the previous handshake. `done` is due one cycle after the last handshake, and `req_ready` one cycle after `done`. The bench samples every output on falling edges and advances its expected-transaction index only on cycles where it drove `txn_ready` high. Stalled cycles must therefore show the same entry again.

During the busy cycles the bench keeps `req_valid` high with unrelated addresses, so that a wrongly accepted request would corrupt the list it compares against.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_FIN   = 2'd2
  } coal_state_e;
endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/coal_leader.sv
// Picks the lowest-numbered lane still pending.
module coal_leader #(
  parameter  int LANES = 16,
  localparam int LIW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [LIW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = LIW'(i);
    end
  end
endmodule

// File: rtl/coal_match.sv
// Flags every pending lane sharing the leader's largest segment.
module coal_match #(
  parameter int LANES = 16,
  parameter int SW    = 25,
  parameter int LIW   = 4
) (
  input  logic [LANES*SW-1:0] seg_flat,
  input  logic [LANES-1:0]    pend,
  input  logic [LIW-1:0]      lead,
  output logic [LANES-1:0]    hit
);
  logic [SW-1:0] seg [LANES];
  logic [SW-1:0] lead_seg;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign seg[i] = seg_flat[i*SW +: SW];
  end

  assign lead_seg = seg[lead];

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign hit[i] = pend[i] && (seg[i] == lead_seg);
  end
endmodule

// File: rtl/coal_shrink.sv
// Halves the transaction while all grouped lanes stay in one aligned half.
module coal_shrink #(
  parameter  int LANES   = 16,
  parameter  int AW      = 32,
  parameter  int MIN_LOG = 5,
  parameter  int MAX_LOG = 7,
  parameter  int LIW     = 4,
  parameter  int SZW     = 2,
  localparam int STEPS   = MAX_LOG - MIN_LOG
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    hit,
  input  logic [LIW-1:0]      lead,
  output logic [AW-1:0]       base,
  output logic [SZW-1:0]      size
);
  logic [AW-1:0] a [LANES];
  logic [STEPS:0] keep;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign a[i] = addr_flat[i*AW +: AW];
  end

  assign keep[0] = 1'b1;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    localparam int B = MAX_LOG - 1 - s;
    logic [LANES-1:0] bv;
    logic             mixed;
    for (genvar j = 0; j < LANES; j++) begin : g_bit
      assign bv[j] = a[j][B];
    end
    assign mixed     = (|(hit & bv)) && (|(hit & ~bv));
    assign keep[s+1] = keep[s] && !mixed;
  end

  int unsigned halves;
  int unsigned low;

  always_comb begin
    halves = 0;
    for (int s = 1; s <= STEPS; s++) begin
      if (keep[s]) halves = halves + 1;
    end
    low  = MAX_LOG - halves;
    size = SZW'(STEPS - halves);
    base = a[lead] & ({AW{1'b1}} << low);
  end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
  import coal_pkg::*;
#(
  parameter  int LANES   = 16,
  parameter  int AW      = 32,
  parameter  int MIN_LOG = 5,
  parameter  int MAX_LOG = 7,
  localparam int LIW     = $clog2(LANES),
  localparam int SZW     = $clog2(MAX_LOG - MIN_LOG + 1),
  localparam int SW      = AW - MAX_LOG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [SZW-1:0]      txn_size,
  output logic [LANES-1:0]    txn_lanes,
  output logic                done
);
  logic rst_n_i;
  coal_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  coal_state_e         state_q, state_d;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    pend_q, pend_d;
  logic                load_en, pend_en;
  logic [LIW-1:0]      lead;
  logic [LANES-1:0]    hit;
  logic [LANES*SW-1:0] seg_flat;

  for (genvar i = 0; i < LANES; i++) begin : g_seg
    assign seg_flat[i*SW +: SW] = addr_q[i*AW + MAX_LOG +: SW];
  end

  coal_leader #(.LANES(LANES)) u_lead (.pend(pend_q), .idx(lead));

  coal_match #(.LANES(LANES), .SW(SW), .LIW(LIW)) u_match (
    .seg_flat(seg_flat), .pend(pend_q), .lead(lead), .hit(hit)
  );

  coal_shrink #(
    .LANES(LANES), .AW(AW), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
    .LIW(LIW), .SZW(SZW)
  ) u_shrink (
    .addr_flat(addr_q), .hit(hit), .lead(lead),
    .base(txn_base), .size(txn_size)
  );

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    pend_en = 1'b0;
    pend_d  = pend_q;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          load_en = 1'b1;
          pend_en = 1'b1;
          pend_d  = req_active;
          state_d = (|req_active) ? S_ISSUE : S_FIN;
        end
      end
      S_ISSUE: begin
        if (txn_ready) begin
          pend_en = 1'b1;
          pend_d  = pend_q & ~hit;
          if ((pend_q & ~hit) == '0) state_d = S_FIN;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     addr_q <= '0;
    else if (load_en) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign req_ready = (state_q == S_IDLE);
  assign txn_valid = (state_q == S_ISSUE);
  assign txn_lanes = hit;
  assign done      = (state_q == S_FIN);
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES   = 16,
  parameter int AW      = 32,
  parameter int MIN_LOG = 5,
  parameter int MAX_LOG = 7,
  parameter int SZW     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [AW-1:0]    txn_base,
  input logic [SZW-1:0]   txn_size,
  input logic [LANES-1:0] txn_lanes,
  input logic             done
);
  logic [AW-1:0] low_bits;
  assign low_bits = ~({AW{1'b1}} << (MIN_LOG + int'(txn_size)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!txn_valid && !done));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=>
      (txn_valid && $stable(txn_base) && $stable(txn_size) && $stable(txn_lanes)));

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((int'(txn_size) <= MAX_LOG - MIN_LOG) && ((txn_base & low_bits) == '0)));

  p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes != '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  p_done_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txn_valid && !req_ready));
endmodule

bind mem_coalescer coal_checker #(
  .LANES(LANES), .AW(AW), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SZW(SZW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
  .txn_size(txn_size), .txn_lanes(txn_lanes), .done(done)
);

// File: tb/mem_coalescer_tb.sv
module mem_coalescer_tb;
  localparam int L = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [L-1:0]  req_active;
  logic [L*32-1:0] req_addr;
  logic          txn_valid;
  logic          txn_ready;
  logic [31:0]   txn_base;
  logic [1:0]    txn_size;
  logic [L-1:0]  txn_lanes;
  logic          done;

  always #2.5 clk = ~clk;

  mem_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_size(txn_size),
    .txn_lanes(txn_lanes), .done(done)
  );

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] la [L];
  logic [L-1:0] lact;
  logic [31:0] e_base [L];
  logic [1:0]  e_size [L];
  logic [L-1:0] e_mask [L];
  int e_n;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected list from the requirements, min/max span per segment
  task automatic build_exp();
    logic [L-1:0] served = '0;
    e_n = 0;
    forever begin
      int lead = -1;
      logic [31:0] lo, hi, seg;
      logic [L-1:0] m;
      for (int i = L - 1; i >= 0; i--) if (lact[i] && !served[i]) lead = i;
      if (lead < 0) break;
      seg = la[lead] / 128;
      m = '0; lo = 32'hFFFF_FFFF; hi = 0;
      for (int j = 0; j < L; j++) begin
        if (lact[j] && !served[j] && (la[j] / 128 == seg)) begin
          logic [31:0] w;
          w = la[j] & ~32'd3;
          m[j] = 1'b1;
          if (w < lo) lo = w;
          if (w + 3 > hi) hi = w + 3;
        end
      end
      for (int c = 2; c >= 0; c--) begin
        int s = 32 << c;
        if (lo / s == hi / s) begin
          e_size[e_n] = 2'(c);
          e_base[e_n] = (lo / s) * s;
        end
      end
      e_mask[e_n] = m;
      served |= m;
      e_n++;
    end
  endtask

  task automatic run_req(input string tag, input bit stall);
    int k = 0;
    int cyc = 0;
    bit got_done = 0;
    build_exp();
    @(negedge clk);
    chk(req_ready === 1'b1, {"R2 idle ready before ", tag}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_active = lact;
    for (int j = 0; j < L; j++) req_addr[j*32 +: 32] = la[j];
    @(negedge clk);
    // unrelated request held during busy cycles must be ignored (R9)
    req_active = '1;
    for (int j = 0; j < L; j++) req_addr[j*32 +: 32] = 32'hF000_0000 + 32'(j) * 32'd256;
    while (!got_done && cyc < 64) begin
      if (cyc == 0)
        chk(txn_valid === (e_n > 0) && done === (e_n == 0), {"R2 first result cycle ", tag},
            64'({txn_valid, done}), 64'({e_n > 0, e_n == 0}));
      if (done) begin
        got_done = 1;
        chk(k == e_n, {"R9 done after last txn ", tag}, 64'(k), 64'(e_n));
      end else if (txn_valid) begin
        if (k >= e_n) chk(1'b0, {"R3 extra txn ", tag}, 64'(k), 64'(e_n));
        else chk({txn_base, txn_size, txn_lanes} === {e_base[k], e_size[k], e_mask[k]},
                 {"R3/R4 txn ", tag},
                 64'({txn_base, txn_size, txn_lanes}), 64'({e_base[k], e_size[k], e_mask[k]}));
        txn_ready = stall ? ((cyc % 3) != 1) : 1'b1;
        if (txn_ready) k++;
      end else begin
        chk(1'b0, {"R9 idle gap in busy ", tag}, 64'(txn_valid), 64'd1);
      end
      @(negedge clk);
      cyc++;
    end
    if (!got_done) chk(1'b0, {"R9 no done ", tag}, 64'(0), 64'd1);
    req_valid = 1'b0;
    txn_ready = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0, {"R9 idle after done ", tag},
        64'({req_ready, done}), 64'({1'b1, 1'b0}));
  endtask

  task automatic fill_stride(input logic [31:0] base, input int stride, input logic [L-1:0] act);
    for (int i = 0; i < L; i++) la[i] = base + 32'(i * stride * 4);
    lact = act;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; txn_ready = 1'b1;
    req_active = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1 && txn_valid === 0 && done === 0, "R1 in reset",
        64'({req_ready, txn_valid, done}), 64'(3'b100));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1 && txn_valid === 0 && done === 0, "R1 after reset",
        64'({req_ready, txn_valid, done}), 64'(3'b100));

    // R5: 16 consecutive words, one 64 B transaction
    fill_stride(32'h1000, 1, '1);
    run_req("R5 consecutive", 0);
    // R6: stride 2 -> single 128 B
    fill_stride(32'h2000, 2, '1);
    run_req("R6 stride2", 0);
    chk(e_n == 1 && e_size[0] == 2, "R6 stride2 model", 64'(e_n), 64'd1);
    // R6: stride 3 -> 128 B then 64 B
    fill_stride(32'h2400, 3, '1);
    run_req("R6 stride3", 1);
    chk(e_n == 2 && e_size[0] == 2 && e_size[1] == 1, "R6 stride3 model", 64'(e_n), 64'd2);
    // R5: permuted words inside one 64 B block
    for (int i = 0; i < L; i++) la[i] = 32'h3040 + 32'(((i * 5) % 16) * 4);
    lact = '1;
    run_req("R5 permuted", 0);
    // R7/R4: 8 active lanes in one 32 B block, inactive lanes far away
    for (int i = 0; i < L; i++) la[i] = (i < 8) ? 32'h5060 + 32'((7 - i) * 4) : 32'h9000_0000 + 32'(i * 4096);
    lact = 16'h00FF;
    run_req("R7 inactive far", 0);
    // R7: nothing active
    fill_stride(32'h6000, 1, '0);
    run_req("R7 empty", 0);
    // R3/R10: every lane its own segment, descending addresses
    for (int i = 0; i < L; i++) la[i] = 32'h10000 + 32'((15 - i) * 128 + i * 4);
    lact = '1;
    run_req("R10 scattered", 1);
    chk(e_n == 16, "R10 model count", 64'(e_n), 64'd16);
    // R3: interleaved two segments
    for (int i = 0; i < L; i++) la[i] = 32'h20000 + ((i % 2 == 1) ? 32'h80 : 32'h0) + 32'(i * 4);
    lact = '1;
    run_req("R3 interleave", 1);

    // sweep of strides, offsets and active patterns
    for (int st = 0; st < 9; st++) begin
      for (int off = 0; off < 32; off++) begin
        logic [L-1:0] pat;
        pat = (off % 2 == 0) ? 16'hFFFF : 16'((16'hA5F3 << (off % 16)) | (16'hA5F3 >> (16 - off % 16)));
        fill_stride(32'h4000 + 32'(off * 4), st, pat);
        run_req("R4 sweep", (off % 3) == 0);
      end
    end
    // random addresses in a small window
    for (int r = 0; r < 300; r++) begin
      for (int i = 0; i < L; i++) la[i] = 32'h8000 + (($urandom % 256) * 4) + ($urandom % 4);
      lact = 16'($urandom);
      run_req("R4 random", (r % 2) == 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule